// File: doc/BRIEF.md
# ASID-Tagged Associative TLB Lookup

This block is the translation lookaside structure of a memory management unit: a fully associative table of 64 page entries. Each entry carries a valid flag, a virtual page number, an 8-bit address-space identifier (ASID), a shared flag and a cacheable flag. A lookup presents a page number and the running ASID. Every entry is compared at once, and one cycle later the block reports one of three outcomes: a single hit with its slot and cacheable flag, a miss, or a multiple hit with its exception code.

The block also owns a 32-bit MMU control word. Two 6-bit fields of that word drive replacement: a replacement counter and a replacement boundary. Every lookup advances the counter. The counter wraps early when a nonzero boundary is programmed. A load command writes a fresh entry into the slot the counter currently names, which lets software fill a chosen part of the table. Another bit of the control word, when the CPU runs privileged, switches off the ASID comparison so that a single shared address space can be used.

Top module: `assoc_xlat_tlb`

## Requirements
- R1: An entry whose valid flag is 0 never takes part in a match.
- R2: An entry matches when its page number equals the request page number and at least one of the following is true: ASID checking is off, the entry ASID equals the request ASID, or the entry's shared flag is 1.
- R3: ASID checking is off only when control bit 8 (single-space mode) is 1 and `priv_mode` is 1. In every other case it is on.
- R4: One match gives `res_hit`, with `res_idx` set to that slot and `res_cacheable` set to its cacheable flag. No match gives `res_miss`, with `res_idx` = 0 and `res_cacheable` = 0. Two or more matches give `res_multi`, with `res_exc_code` = 0x140, `res_idx` set to the lowest matching slot and `res_cacheable` = 0. `res_exc_code` is 0 when there is no multiple hit.
- R5: Results are registered. `res_valid` is 1 exactly one cycle after a cycle with `lkp_valid` high and 0 otherwise. The three outcome flags are 0 while `res_valid` is 0.
- R6: The replacement counter sits in control bits 15:10 and the boundary in bits 23:18. A `ctl_wr_en` cycle loads the whole word from `ctl_wr_data`. This write takes precedence over a counter step in the same cycle.
- R7: Each lookup sets the counter to count+1. The result becomes 0 instead when the boundary is nonzero and count+1 exceeds it, or when count+1 exceeds NUM_ENTRIES-1. Without a lookup or a write, the control word holds its value.
- R8: A load command writes the slot named by the current counter value. It takes the ASID and page number from its page-table-entry-high inputs. A load does not move the counter.
- R9: A counter step changes only bits 15:10 of the control word. All other bits keep their value.
- R10: After reset, every valid flag is 0, the control word is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_vpn | input | 22 | Request virtual page number |
| lkp_asid | input | 8 | Running address-space identifier |
| priv_mode | input | 1 | CPU is in privileged mode |
| ctl_wr_en | input | 1 | Write the control word |
| ctl_wr_data | input | 32 | New control word |
| load_en | input | 1 | Load-entry command |
| load_vpn | input | 22 | Page number from the page-table-entry-high input |
| load_asid | input | 8 | ASID from the page-table-entry-high input |
| load_valid | input | 1 | Valid flag of the new entry |
| load_shared | input | 1 | Shared flag of the new entry |
| load_cacheable | input | 1 | Cacheable flag of the new entry |
| ctl_q | output | 32 | Current control word |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Single match |
| res_miss | output | 1 | No match |
| res_multi | output | 1 | Two or more matches |
| res_idx | output | 6 | Matching slot (lowest slot on a multiple hit) |
| res_cacheable | output | 1 | Cacheable flag of the single hit |
| res_exc_code | output | 12 | 0x140 on a multiple hit, else 0 |

## Verification
The assertions check the result handshake on every cycle: the one-cycle latency, exactly one outcome per result, and the exception code tied to the multiple-hit flag. On every cycle they also check that the control word changes only in its counter field unless it is written, that it stays still when idle, and that a write lands exactly. The scenarios alone can show the matching behaviour: ASID filtering, the shared override, single-space suppression gated by privilege, invalid entries, and the lowest-slot choice. The scenarios alone can also show the counter's wrap arithmetic against the boundary and the table size, and that a load lands in the slot the counter names.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W     = 22;
    localparam int ASID_W    = 8;
    localparam int CTL_W     = 32;
    localparam int FLD_W     = 6;
    localparam int CNT_LSB   = 10;
    localparam int BND_LSB   = 18;
    localparam int SVM_BIT   = 8;
    localparam int EXC_W     = 12;
    localparam logic [EXC_W-1:0] MULTI_CODE = 12'h140;
    localparam logic [CTL_W-1:0] CNT_MASK   = ((CTL_W'(1) << FLD_W) - 1) << CNT_LSB;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic              cacheable;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  tlb_entry_t                         wr_entry,
    output tlb_entry_t [NUM_ENTRIES-1:0]       entries_o
);
    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries_o = st_q.ent;
endmodule

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [VPN_W-1:0]             req_vpn,
    input  logic [ASID_W-1:0]            req_asid,
    input  logic                         use_asid,
    output logic [NUM_ENTRIES-1:0]       match_o
);
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
        logic vpn_eq;
        logic asid_ok;
        assign vpn_eq  = (entries[gi].vpn == req_vpn);
        assign asid_ok = !use_asid || entries[gi].shared || (entries[gi].asid == req_asid);
        assign match_o[gi] = entries[gi].valid && vpn_eq && asid_ok;
    end
endmodule

// File: rtl/tlb_hit_encode.sv
module tlb_hit_encode
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0]       match,
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    output logic                         any_o,
    output logic                         many_o,
    output logic [IDX_W-1:0]             low_idx_o,
    output logic                         low_cach_o
);
    always_comb begin
        any_o      = 1'b0;
        many_o     = 1'b0;
        low_idx_o  = '0;
        low_cach_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) begin
                if (!any_o) begin
                    any_o      = 1'b1;
                    low_idx_o  = IDX_W'(i);
                    low_cach_o = entries[i].cacheable;
                end else begin
                    many_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_repl_ctl.sv
module tlb_repl_ctl
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             step,
    output logic [CTL_W-1:0] ctl_o
);
    localparam logic [FLD_W:0] LAST_IDX = (FLD_W+1)'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;

    ctl_state_t cs_d, cs_q;
    logic [FLD_W-1:0] cnt_cur;
    logic [FLD_W-1:0] bnd_cur;
    logic [FLD_W:0]   cnt_inc;
    logic             wrap;

    always_comb begin
        cnt_cur = cs_q.ctl[CNT_LSB +: FLD_W];
        bnd_cur = cs_q.ctl[BND_LSB +: FLD_W];
        cnt_inc = {1'b0, cnt_cur} + 1'b1;
        wrap    = ((bnd_cur != '0) && (cnt_inc > {1'b0, bnd_cur})) || (cnt_inc > LAST_IDX);
        cs_d    = cs_q;
        if (wr_en) begin
            cs_d.ctl = wr_data;
        end else if (step) begin
            cs_d.ctl[CNT_LSB +: FLD_W] = wrap ? '0 : cnt_inc[FLD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ctl_o = cs_q.ctl;
endmodule

// File: rtl/assoc_xlat_tlb.sv
module assoc_xlat_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [ASID_W-1:0] lkp_asid,
    input  logic              priv_mode,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    input  logic              load_en,
    input  logic [VPN_W-1:0]  load_vpn,
    input  logic [ASID_W-1:0] load_asid,
    input  logic              load_valid,
    input  logic              load_shared,
    input  logic              load_cacheable,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_multi,
    output logic [IDX_W-1:0]  res_idx,
    output logic              res_cacheable,
    output logic [EXC_W-1:0]  res_exc_code
);
    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             miss;
        logic             multi;
        logic [IDX_W-1:0] idx;
        logic             cach;
        logic [EXC_W-1:0] code;
    } res_t;

    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    tlb_entry_t                   new_entry;
    logic [NUM_ENTRIES-1:0]       match;
    logic                         use_asid;
    logic                         any_m, many_m, low_cach;
    logic [IDX_W-1:0]             low_idx;
    res_t                         res_d, res_q;

    assign use_asid = !(ctl_q[SVM_BIT] && priv_mode);

    always_comb begin
        new_entry.valid     = load_valid;
        new_entry.vpn       = load_vpn;
        new_entry.asid      = load_asid;
        new_entry.shared    = load_shared;
        new_entry.cacheable = load_cacheable;
    end

    tlb_repl_ctl #(.NUM_ENTRIES(NUM_ENTRIES)) u_repl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .step    (lkp_valid),
        .ctl_o   (ctl_q)
    );

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (load_en),
        .wr_idx    (ctl_q[CNT_LSB +: IDX_W]),
        .wr_entry  (new_entry),
        .entries_o (entries)
    );

    tlb_match_vec #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .entries  (entries),
        .req_vpn  (lkp_vpn),
        .req_asid (lkp_asid),
        .use_asid (use_asid),
        .match_o  (match)
    );

    tlb_hit_encode #(.NUM_ENTRIES(NUM_ENTRIES)) u_enc (
        .match      (match),
        .entries    (entries),
        .any_o      (any_m),
        .many_o     (many_m),
        .low_idx_o  (low_idx),
        .low_cach_o (low_cach)
    );

    always_comb begin
        res_d = '0;
        if (lkp_valid) begin
            res_d.vld   = 1'b1;
            res_d.hit   = any_m && !many_m;
            res_d.miss  = !any_m;
            res_d.multi = many_m;
            res_d.idx   = low_idx;
            res_d.cach  = any_m && !many_m && low_cach;
            res_d.code  = many_m ? MULTI_CODE : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid     = res_q.vld;
    assign res_hit       = res_q.hit;
    assign res_miss      = res_q.miss;
    assign res_multi     = res_q.multi;
    assign res_idx       = res_q.idx;
    assign res_cacheable = res_q.cach;
    assign res_exc_code  = res_q.code;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_valid,
    input logic             ctl_wr_en,
    input logic [CTL_W-1:0] ctl_wr_data,
    input logic [CTL_W-1:0] ctl_q,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_multi,
    input logic             res_cacheable,
    input logic [EXC_W-1:0] res_exc_code
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $countones({res_hit, res_miss, res_multi}) == 1); // R4
    AST_MULTI_CODE: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_multi) |-> res_exc_code == MULTI_CODE); // R4
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !res_multi |-> res_exc_code == '0); // R4
    AST_MISS_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n) res_miss |-> !res_cacheable); // R4
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lkp_valid |=> res_valid); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !lkp_valid |=> !res_valid); // R5
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> !(res_hit || res_miss || res_multi)); // R5
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr_en |=> ctl_q == $past(ctl_wr_data)); // R6
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ctl_wr_en && !lkp_valid) |=> $stable(ctl_q)); // R7
    AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) !ctl_wr_en |=> (ctl_q & ~CNT_MASK) == ($past(ctl_q) & ~CNT_MASK)); // R9
endmodule

bind assoc_xlat_tlb tlb_checker u_chk (.*);

// File: tb/tb_assoc_xlat_tlb.sv
module tb_assoc_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [21:0] lkp_vpn = '0;
    logic [7:0]  lkp_asid = '0;
    logic        priv_mode = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        load_en = 1'b0;
    logic [21:0] load_vpn = '0;
    logic [7:0]  load_asid = '0;
    logic        load_valid = 1'b0;
    logic        load_shared = 1'b0;
    logic        load_cacheable = 1'b0;
    logic [31:0] ctl_q;
    logic        res_valid, res_hit, res_miss, res_multi, res_cacheable;
    logic [5:0]  res_idx;
    logic [11:0] res_exc_code;

    always #10 clk = ~clk;

    assoc_xlat_tlb dut (.*);

    typedef struct packed {
        logic        hit;
        logic        miss;
        logic        multi;
        logic [5:0]  idx;
        logic        cach;
        logic [11:0] code;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;

    logic        m_valid [64];
    logic [21:0] m_vpn   [64];
    logic [7:0]  m_asid  [64];
    logic        m_sh    [64];
    logic        m_c     [64];
    logic [31:0] m_ctl = '0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step_ctl(input logic [31:0] c);
        logic [6:0]  nx;
        logic [5:0]  bnd;
        logic [31:0] r;
        nx  = {1'b0, c[15:10]} + 7'd1;
        bnd = c[23:18];
        r   = c;
        if ((bnd != 0 && nx > {1'b0, bnd}) || nx > 7'd63) r[15:10] = 6'd0;
        else r[15:10] = nx[5:0];
        return r;
    endfunction

    function automatic exp_t model_lookup(input logic [21:0] vpn, input logic [7:0] asid,
                                          input logic priv);
        exp_t e;
        int   n;
        logic chk_asid;
        e = '0;
        n = 0;
        chk_asid = !(m_ctl[8] && priv);
        for (int i = 0; i < 64; i++) begin
            if (m_valid[i] && m_vpn[i] == vpn && (!chk_asid || m_sh[i] || m_asid[i] == asid)) begin
                if (n == 0) begin
                    e.idx  = 6'(i);
                    e.cach = m_c[i];
                end
                n++;
            end
        end
        if (n == 0) begin
            e.miss = 1'b1;
            e.cach = 1'b0;
        end else if (n == 1) begin
            e.hit = 1'b1;
        end else begin
            e.multi = 1'b1;
            e.cach  = 1'b0;
            e.code  = 12'h140;
        end
        return e;
    endfunction

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "result without lookup", 64'(res_valid), 64'd0);
            end else begin
                exp_t  e;
                exp_t  g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = '{res_hit, res_miss, res_multi, res_idx, res_cacheable, res_exc_code};
                check(g == e, t, "lookup result", 64'(g), 64'(e));
            end
        end
    end

    task automatic ctl_write(input logic [31:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        m_ctl = d;
    endtask

    task automatic tlb_load(input logic [21:0] vpn, input logic [7:0] asid,
                            input logic sh, input logic c, input logic v);
        int k;
        @(negedge clk);
        k = int'(m_ctl[15:10]);
        load_en = 1'b1;
        load_vpn = vpn;
        load_asid = asid;
        load_shared = sh;
        load_cacheable = c;
        load_valid = v;
        m_valid[k] = v;
        m_vpn[k] = vpn;
        m_asid[k] = asid;
        m_sh[k] = sh;
        m_c[k] = c;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic load_at(input int slot, input logic [21:0] vpn, input logic [7:0] asid,
                           input logic sh, input logic c, input logic v);
        ctl_write((m_ctl & ~32'h0000_FC00) | (32'(slot) << 10));
        tlb_load(vpn, asid, sh, c, v);
    endtask

    task automatic lookup(input logic [21:0] vpn, input logic [7:0] asid,
                          input logic priv, input string tag);
        @(negedge clk);
        exp_q.push_back(model_lookup(vpn, asid, priv));
        tag_q.push_back(tag);
        lkp_valid = 1'b1;
        lkp_vpn = vpn;
        lkp_asid = asid;
        priv_mode = priv;
        m_ctl = step_ctl(m_ctl);
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic expect_result(input logic h, input logic mi, input logic mu,
                                 input logic [5:0] idx, input string req);
        exp_t e;
        e = exp_q[exp_q.size()-1];
        check(e.hit == h && e.miss == mi && e.multi == mu && (!h || e.idx == idx),
              req, "scenario outcome", 64'({e.hit, e.miss, e.multi, e.idx}),
              64'({h, mi, mu, idx}));
    endtask

    task automatic check_ctl(input string req);
        check(ctl_q == m_ctl, req, "control word", 64'(ctl_q), 64'(m_ctl));
    endtask

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_sh[i] = 1'b0; m_c[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(ctl_q == 32'd0, "R10", "control after reset", 64'(ctl_q), 64'd0);
        check({res_valid, res_hit, res_miss, res_multi} == 4'b0, "R10", "outputs in reset",
              64'({res_valid, res_hit, res_miss, res_multi}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: table empty after reset, so any page misses
        lookup(22'd0, 8'd0, 1'b0, "R10");
        expect_result(1'b0, 1'b1, 1'b0, 6'd0, "R10");
        check_ctl("R7");
        @(negedge clk);
        check(res_valid == 1'b0, "R5", "valid drops after one cycle", 64'(res_valid), 64'd0);

        // R2/R4: ASID-matched private entry with cacheable flag
        load_at(5, 22'h01234, 8'd7, 1'b0, 1'b1, 1'b1);
        check_ctl("R8");
        lookup(22'h01234, 8'd7, 1'b0, "R2_R4 hit");
        expect_result(1'b1, 1'b0, 1'b0, 6'd5, "R4");
        lookup(22'h01234, 8'd8, 1'b0, "R2 asid mismatch");
        expect_result(1'b0, 1'b1, 1'b0, 6'd0, "R2");
        lookup(22'h01235, 8'd7, 1'b0, "R2 vpn mismatch");

        // R2: shared entry ignores ASID
        load_at(9, 22'h02000, 8'd3, 1'b1, 1'b0, 1'b1);
        lookup(22'h02000, 8'd50, 1'b0, "R2 shared");
        expect_result(1'b1, 1'b0, 1'b0, 6'd9, "R2");

        // R1: invalid entry never matches
        load_at(12, 22'h03000, 8'd4, 1'b0, 1'b1, 1'b0);
        lookup(22'h03000, 8'd4, 1'b0, "R1 invalid");
        expect_result(1'b0, 1'b1, 1'b0, 6'd0, "R1");

        // R3: single-space mode suppresses ASID only when privileged
        ctl_write(m_ctl | 32'h0000_0100);
        lookup(22'h01234, 8'd99, 1'b1, "R3 sv priv");
        expect_result(1'b1, 1'b0, 1'b0, 6'd5, "R3");
        lookup(22'h01234, 8'd99, 1'b0, "R3 sv user");
        expect_result(1'b0, 1'b1, 1'b0, 6'd0, "R3");
        ctl_write(m_ctl & ~32'h0000_0100);
        lookup(22'h01234, 8'd99, 1'b1, "R3 no sv priv");
        expect_result(1'b0, 1'b1, 1'b0, 6'd0, "R3");

        // R4: multiple hit reports lowest slot and code 0x140
        load_at(20, 22'h01234, 8'd7, 1'b0, 1'b1, 1'b1);
        load_at(3, 22'h01234, 8'd1, 1'b0, 1'b1, 1'b1);
        lookup(22'h01234, 8'd7, 1'b0, "R4 multi");
        expect_result(1'b0, 1'b0, 1'b1, 6'd5, "R4");
        lookup(22'h01234, 8'd1, 1'b0, "R4 single low");
        expect_result(1'b1, 1'b0, 1'b0, 6'd3, "R4");

        // R7: wrap at last index with boundary zero
        ctl_write(32'd62 << 10);
        lookup(22'h00aaa, 8'd0, 1'b0, "R7");
        check(ctl_q[15:10] == 6'd63, "R7", "count to 63", 64'(ctl_q[15:10]), 64'd63);
        lookup(22'h00aaa, 8'd0, 1'b0, "R7");
        check(ctl_q[15:10] == 6'd0, "R7", "wrap at table end", 64'(ctl_q[15:10]), 64'd0);

        // R7: wrap at programmed boundary 3
        ctl_write(32'd3 << 18);
        for (int i = 0; i < 4; i++) begin
            lookup(22'h00bbb, 8'd0, 1'b0, "R7");
            check_ctl("R7");
        end
        check(ctl_q[15:10] == 6'd0, "R7", "wrap at boundary", 64'(ctl_q[15:10]), 64'd0);
        ctl_write((32'd3 << 18) | (32'd10 << 10));
        lookup(22'h00bbb, 8'd0, 1'b0, "R7");
        check(ctl_q[15:10] == 6'd0, "R7", "count above boundary", 64'(ctl_q[15:10]), 64'd0);

        // R9: counter step keeps every other bit
        ctl_write(32'hFF00_00FF | (32'd40 << 18) | (32'd5 << 10));
        lookup(22'h00ccc, 8'd0, 1'b0, "R9");
        check(ctl_q == (32'hFF00_00FF | (32'd40 << 18) | (32'd6 << 10)), "R9", "preserved bits",
              64'(ctl_q), 64'(32'hFF00_00FF | (32'd40 << 18) | (32'd6 << 10)));

        // R8: load lands in the slot the counter reached
        ctl_write(32'd30 << 10);
        lookup(22'h00ddd, 8'd0, 1'b0, "R8");
        tlb_load(22'h07777, 8'd2, 1'b0, 1'b1, 1'b1);
        check_ctl("R8");
        lookup(22'h07777, 8'd2, 1'b0, "R8 slot");
        expect_result(1'b1, 1'b0, 1'b0, 6'd31, "R8");

        // R6: write wins over a lookup step in the same cycle
        @(negedge clk);
        exp_q.push_back(model_lookup(22'h07777, 8'd2, 1'b0));
        tag_q.push_back("R6 concurrent");
        lkp_valid = 1'b1; lkp_vpn = 22'h07777; lkp_asid = 8'd2; priv_mode = 1'b0;
        ctl_wr_en = 1'b1; ctl_wr_data = (32'd2 << 18) | (32'd17 << 10);
        m_ctl = (32'd2 << 18) | (32'd17 << 10);
        @(negedge clk);
        lkp_valid = 1'b0; ctl_wr_en = 1'b0;
        check(ctl_q[15:10] == 6'd17, "R6", "write precedence", 64'(ctl_q[15:10]), 64'd17);
        check(ctl_q[23:18] == 6'd2, "R6", "boundary field", 64'(ctl_q[23:18]), 64'd2);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all results seen", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule